// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA Request Unit

This unit sits beside the two 16-entry data queues of an SPI port and turns their activity into status, interrupts and DMA requests. It follows the fill of both queues from their push and pop strobes, keeps sticky overflow and underrun flags, and builds a seven-bit raw interrupt vector. That vector combines watermark comparisons, occupancy conditions, a receive-overrun event and a receive timeout counted in SCK periods. A mask register gates the vector into a masked vector and a single interrupt line.

For each direction there is a single DMA request and a burst request for four words. Software writes to the mask and clear inputs both clear interrupts, and clearing the overrun interrupt also empties the receive queue. A soft reset empties everything in one cycle. The queue storage and the shift engine sit outside this unit: the unit tells the storage when to flush through `rx_flush`.

Top module: `spi_fifo_irqdma`

## Requirements
- R1: Each level counts 0 to 16. A push to a queue that is not full adds one and a pop from a queue that is not empty removes one. A push and a pop in the same cycle leave the level unchanged. All changes show one cycle after the strobe.
- R2: `tx_empty` is 1 when the transmit level is 0 and `tx_not_full` is 1 when it is below 16. `rx_not_empty` is 1 when the receive level is above 0 and `rx_full` is 1 when it is 16.
- R3: A push while full is dropped and sets the sticky overflow flag of that queue. A pop while empty sets its sticky underrun flag. Only a soft reset clears these flags.
- R4: Raw bit positions: bit 2 = receive level > `rx_wm`, bit 3 = transmit level < `tx_wm`, bit 4 = receive not empty, bit 5 = receive full, bit 6 = transmit empty. These five bits follow their conditions directly.
- R5: Raw bit 0 (receive overrun) is set one cycle after a receive push while the receive queue is full. It stays set until it is cleared.
- R6: Raw bit 1 (receive timeout) is set one cycle after the 32nd `sck_tick` counted while the receive queue is non-empty and not popped. A pop, an empty queue or a clear of bit 1 restarts the count. The bit is sticky.
- R7: A write on the clear port clears raw bits 0 and 1 wherever the written value has a 1. Writing 1 to bit 0 also asserts `rx_flush` in that cycle and empties the receive queue.
- R8: A mask write stores the mask and also clears the interrupts written 1, with the same effects as R7.
- R9: `masked_irq` is `raw_irq` AND the mask, and `irq` is the OR of `masked_irq`.
- R10: `rx_dma_single` is 1 when the receive level is at least 1. `rx_dma_burst` is 1 when the receive level is at least 4.
- R11: `tx_dma_single` is 1 when the transmit level is below 16. `tx_dma_burst` is 1 when at least 4 entries are free, that is, when the level is at most 12.
- R12: All requests of a direction are 0 while that direction's DMA enable is 0 or `mod_en` is 0.
- R13: A soft reset clears both levels, all four sticky flags and raw bits 0 and 1 in one cycle, and keeps the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable, gates DMA requests |
| soft_rst | input | 1 | One-cycle soft reset strobe |
| tx_push | input | 1 | Word written into transmit queue |
| tx_pop | input | 1 | Word taken by shift engine |
| rx_push | input | 1 | Word received from shift engine |
| rx_pop | input | 1 | Word read out of receive queue |
| sck_tick | input | 1 | One pulse per SCK period |
| tx_wm | input | 4 | Transmit watermark |
| rx_wm | input | 4 | Receive watermark |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 7 | Mask write value |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 7 | Clear write value |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_level | output | 5 | Transmit fill count |
| rx_level | output | 5 | Receive fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_full | output | 1 | Receive queue full |
| tx_ovfl | output | 1 | Sticky transmit overflow |
| tx_undr | output | 1 | Sticky transmit underrun |
| rx_ovfl | output | 1 | Sticky receive overflow |
| rx_undr | output | 1 | Sticky receive underrun |
| rx_flush | output | 1 | Flush strobe to receive storage |
| raw_irq | output | 7 | Unmasked interrupt vector |
| masked_irq | output | 7 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| rx_dma_single | output | 1 | Receive single request |
| rx_dma_burst | output | 1 | Receive burst request |
| tx_dma_single | output | 1 | Transmit single request |
| tx_dma_burst | output | 1 | Transmit burst request |

## Verification
Both queues are stepped through every level from 0 to 16. At each level the bench sweeps all sixteen watermark values, which separates the strict "above" comparison used for receive from the strict "below" comparison used for transmit and exposes off-by-one errors at the burst thresholds of 4 and 12. The timeout is driven with 31 ticks and then with 32 ticks, and again after a pop in the middle of the count, to tell a correct restart from a free-running counter. Clear writes and mask writes are applied with single bits set, which shows that each clears only its own interrupt and that only bit 0 flushes the receive queue.

// File: rtl/sfid_pkg.sv
package sfid_pkg;
    localparam int NIRQ      = 7;
    localparam int IRQ_ROR   = 0;
    localparam int IRQ_RT    = 1;
    localparam int IRQ_RXWM  = 2;
    localparam int IRQ_TXWM  = 3;
    localparam int IRQ_RXNE  = 4;
    localparam int IRQ_RXF   = 5;
    localparam int IRQ_TXE   = 6;
endpackage

// File: rtl/sfid_level.sv
module sfid_level #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovfl,
    output logic          undr
);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

    typedef struct packed {
        logic [LW-1:0] lvl;
        logic          ovfl;
        logic          undr;
    } lvl_st_t;

    lvl_st_t st_d, st_q;
    logic    push_ok, pop_ok;

    assign full  = (st_q.lvl == FULL_L);
    assign empty = (st_q.lvl == '0);

    always_comb begin
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        st_d    = st_q;
        if (push && !push_ok) st_d.ovfl = 1'b1;
        if (pop && !pop_ok)   st_d.undr = 1'b1;
        if (push_ok && !pop_ok)      st_d.lvl = st_q.lvl + LW'(1);
        else if (pop_ok && !push_ok) st_d.lvl = st_q.lvl - LW'(1);
        if (flush) st_d.lvl = '0;
        if (wipe)  st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign ovfl  = st_q.ovfl;
    assign undr  = st_q.undr;

    // R1: level never exceeds depth
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= FULL_L);
    // R3: push into a full queue is dropped and flagged
    p_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush && !wipe |=> ovfl && $stable(level));
    // R3: pop from an empty queue is flagged
    p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !wipe |=> undr);
    // R3: sticky flags hold until wipe
    p_ovfl_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl && !wipe |=> ovfl);
endmodule

// File: rtl/sfid_timeout.sv
module sfid_timeout #(
    parameter int PERIODS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic armed,
    input  logic pop,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(PERIODS + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);
    localparam logic [CW-1:0] SAT  = CW'(PERIODS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } to_st_t;

    to_st_t st_d, st_q;

    always_comb begin
        expire = tick && armed && !pop && !restart && (st_q.cnt == LAST);
        st_d   = st_q;
        if (restart || pop || !armed)
            st_d.cnt = '0;
        else if (tick && st_q.cnt != SAT)
            st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: timeout fires once per expiry, never on consecutive cycles
    p_expire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/spi_fifo_irqdma.sv
module spi_fifo_irqdma
    import sfid_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int WM_W    = 4,
    parameter int BURST   = 4,
    parameter int TO_SCK  = 32,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mod_en,
    input  logic            soft_rst,
    input  logic            tx_push,
    input  logic            tx_pop,
    input  logic            rx_push,
    input  logic            rx_pop,
    input  logic            sck_tick,
    input  logic [WM_W-1:0] tx_wm,
    input  logic [WM_W-1:0] rx_wm,
    input  logic            mask_wr,
    input  logic [NIRQ-1:0] mask_wdata,
    input  logic            clr_wr,
    input  logic [NIRQ-1:0] clr_wdata,
    input  logic            tx_dma_en,
    input  logic            rx_dma_en,
    output logic [LW-1:0]   tx_level,
    output logic [LW-1:0]   rx_level,
    output logic            tx_empty,
    output logic            tx_not_full,
    output logic            rx_not_empty,
    output logic            rx_full,
    output logic            tx_ovfl,
    output logic            tx_undr,
    output logic            rx_ovfl,
    output logic            rx_undr,
    output logic            rx_flush,
    output logic [NIRQ-1:0] raw_irq,
    output logic [NIRQ-1:0] masked_irq,
    output logic            irq,
    output logic            rx_dma_single,
    output logic            rx_dma_burst,
    output logic            tx_dma_single,
    output logic            tx_dma_burst
);
    localparam logic [LW-1:0] BURST_L  = LW'(BURST);
    localparam logic [LW-1:0] TX_BMAX  = LW'(DEPTH - BURST);

    typedef struct packed {
        logic            ror;
        logic            rt;
        logic [NIRQ-1:0] mask;
    } irq_st_t;

    irq_st_t         st_d, st_q;
    logic [NIRQ-1:0] clr_vec;
    logic            tx_full, rx_empty, to_expire, to_restart;

    always_comb begin
        clr_vec = (clr_wr ? clr_wdata : '0) | (mask_wr ? mask_wdata : '0);
    end

    assign rx_flush   = soft_rst || clr_vec[IRQ_ROR];
    assign to_restart = rx_flush || clr_vec[IRQ_RT];

    sfid_level #(.DEPTH(DEPTH)) u_tx_level (
        .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .flush(soft_rst),
        .push(tx_push), .pop(tx_pop), .level(tx_level),
        .full(tx_full), .empty(tx_empty), .ovfl(tx_ovfl), .undr(tx_undr)
    );

    sfid_level #(.DEPTH(DEPTH)) u_rx_level (
        .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .flush(rx_flush),
        .push(rx_push), .pop(rx_pop), .level(rx_level),
        .full(rx_full), .empty(rx_empty), .ovfl(rx_ovfl), .undr(rx_undr)
    );

    sfid_timeout #(.PERIODS(TO_SCK)) u_rx_timeout (
        .clk(clk), .rst_n(rst_n), .restart(to_restart), .armed(!rx_empty),
        .pop(rx_pop), .tick(sck_tick), .expire(to_expire)
    );

    assign tx_not_full  = !tx_full;
    assign rx_not_empty = !rx_empty;

    always_comb begin
        st_d = st_q;
        if (mask_wr) st_d.mask = mask_wdata;
        if (rx_push && rx_full) st_d.ror = 1'b1;
        if (to_expire)          st_d.rt  = 1'b1;
        if (clr_vec[IRQ_ROR] || soft_rst) st_d.ror = 1'b0;
        if (clr_vec[IRQ_RT]  || soft_rst) st_d.rt  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_irq           = '0;
        raw_irq[IRQ_ROR]  = st_q.ror;
        raw_irq[IRQ_RT]   = st_q.rt;
        raw_irq[IRQ_RXWM] = rx_level > {{(LW-WM_W){1'b0}}, rx_wm};
        raw_irq[IRQ_TXWM] = tx_level < {{(LW-WM_W){1'b0}}, tx_wm};
        raw_irq[IRQ_RXNE] = !rx_empty;
        raw_irq[IRQ_RXF]  = rx_full;
        raw_irq[IRQ_TXE]  = tx_empty;
        masked_irq        = raw_irq & st_q.mask;
        irq               = |masked_irq;
    end

    always_comb begin
        rx_dma_single = mod_en && rx_dma_en && !rx_empty;
        rx_dma_burst  = mod_en && rx_dma_en && (rx_level >= BURST_L);
        tx_dma_single = mod_en && tx_dma_en && !tx_full;
        tx_dma_burst  = mod_en && tx_dma_en && (tx_level <= TX_BMAX);
    end

    // R5: push into full receive queue raises overrun
    p_ror_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full && !rx_flush |=> raw_irq[IRQ_ROR]);
    // R5: overrun holds until cleared
    p_ror_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_irq[IRQ_ROR] && !rx_flush |=> raw_irq[IRQ_ROR]);
    // R7: clearing overrun empties the receive queue
    p_ror_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[IRQ_ROR] |=> rx_level == '0 && !raw_irq[IRQ_ROR]);
    // R8: a mask write is stored
    p_mask_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> st_q.mask == $past(mask_wdata));
    // R13: soft reset empties and clears in one cycle
    p_soft_rst_r13: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> tx_level == '0 && rx_level == '0 && raw_irq[1:0] == 2'b00
                     && !tx_ovfl && !rx_ovfl && !tx_undr && !rx_undr);
endmodule

// File: tb/spi_fifo_irqdma_bench.sv
module spi_fifo_irqdma_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b0, soft_rst = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic       sck_tick = 1'b0;
    logic [3:0] tx_wm = 4'd0, rx_wm = 4'd0;
    logic       mask_wr = 1'b0, clr_wr = 1'b0;
    logic [6:0] mask_wdata = 7'd0, clr_wdata = 7'd0;
    logic       tx_dma_en = 1'b0, rx_dma_en = 1'b0;
    logic [4:0] tx_level, rx_level;
    logic       tx_empty, tx_not_full, rx_not_empty, rx_full;
    logic       tx_ovfl, tx_undr, rx_ovfl, rx_undr, rx_flush;
    logic [6:0] raw_irq, masked_irq;
    logic       irq, rx_dma_single, rx_dma_burst, tx_dma_single, tx_dma_burst;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    spi_fifo_irqdma u_spi_fifo_irqdma (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .soft_rst(soft_rst),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .sck_tick(sck_tick), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .tx_not_full(tx_not_full),
        .rx_not_empty(rx_not_empty), .rx_full(rx_full),
        .tx_ovfl(tx_ovfl), .tx_undr(tx_undr), .rx_ovfl(rx_ovfl), .rx_undr(rx_undr),
        .rx_flush(rx_flush), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .rx_dma_single(rx_dma_single), .rx_dma_burst(rx_dma_burst),
        .tx_dma_single(tx_dma_single), .tx_dma_burst(tx_dma_burst)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_tx(int n);
        for (int i = 0; i < n; i++) begin tx_push = 1'b1; step(); tx_push = 1'b0; end
    endtask
    task automatic pop_tx(int n);
        for (int i = 0; i < n; i++) begin tx_pop = 1'b1; step(); tx_pop = 1'b0; end
    endtask
    task automatic push_rx(int n);
        for (int i = 0; i < n; i++) begin rx_push = 1'b1; step(); rx_push = 1'b0; end
    endtask
    task automatic pop_rx(int n);
        for (int i = 0; i < n; i++) begin rx_pop = 1'b1; step(); rx_pop = 1'b0; end
    endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin sck_tick = 1'b1; step(); sck_tick = 1'b0; end
    endtask
    task automatic clr(logic [6:0] v);
        clr_wr = 1'b1; clr_wdata = v; step(); clr_wr = 1'b0; clr_wdata = '0;
    endtask
    task automatic wmask(logic [6:0] v);
        mask_wr = 1'b1; mask_wdata = v; step(); mask_wr = 1'b0; mask_wdata = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // reset state
        chk("R1", "tx_level reset", int'(tx_level), 0);
        chk("R1", "rx_level reset", int'(rx_level), 0);
        chk("R4", "raw reset (tx empty only)", int'(raw_irq), 64);
        chk("R9", "irq reset", int'(irq), 0);
        chk("R12", "dma reset", int'({rx_dma_single, rx_dma_burst, tx_dma_single, tx_dma_burst}), 0);

        mod_en = 1'b1; tx_dma_en = 1'b1; rx_dma_en = 1'b1;
        #1;
        // transmit level sweep
        for (int lvl = 0; lvl <= 16; lvl++) begin
            chk("R1", "tx_level", int'(tx_level), lvl);
            chk("R2", "tx_empty", int'(tx_empty), int'(lvl == 0));
            chk("R2", "tx_not_full", int'(tx_not_full), int'(lvl < 16));
            chk("R11", "tx_dma_single", int'(tx_dma_single), int'(lvl < 16));
            chk("R11", "tx_dma_burst", int'(tx_dma_burst), int'(16 - lvl >= 4));
            chk("R4", "raw tx empty bit6", int'(raw_irq[6]), int'(lvl == 0));
            for (int wm = 0; wm < 16; wm++) begin
                tx_wm = 4'(wm);
                #1;
                chk("R4", "raw tx watermark bit3", int'(raw_irq[3]), int'(lvl < wm));
            end
            tx_wm = 4'd0;
            if (lvl < 16) push_tx(1);
        end
        push_tx(1);
        chk("R3", "tx push when full keeps level", int'(tx_level), 16);
        chk("R3", "tx overflow sticky", int'(tx_ovfl), 1);
        pop_tx(16);
        chk("R1", "tx drained", int'(tx_level), 0);
        chk("R3", "tx underrun clear before", int'(tx_undr), 0);
        pop_tx(1);
        chk("R3", "tx underrun on empty pop", int'(tx_undr), 1);
        chk("R3", "tx pop when empty keeps level", int'(tx_level), 0);

        // receive level sweep
        for (int lvl = 0; lvl <= 16; lvl++) begin
            chk("R1", "rx_level", int'(rx_level), lvl);
            chk("R2", "rx_not_empty", int'(rx_not_empty), int'(lvl > 0));
            chk("R2", "rx_full", int'(rx_full), int'(lvl == 16));
            chk("R10", "rx_dma_single", int'(rx_dma_single), int'(lvl >= 1));
            chk("R10", "rx_dma_burst", int'(rx_dma_burst), int'(lvl >= 4));
            chk("R4", "raw rx not empty bit4", int'(raw_irq[4]), int'(lvl > 0));
            chk("R4", "raw rx full bit5", int'(raw_irq[5]), int'(lvl == 16));
            for (int wm = 0; wm < 16; wm++) begin
                rx_wm = 4'(wm);
                #1;
                chk("R4", "raw rx watermark bit2", int'(raw_irq[2]), int'(lvl > wm));
            end
            rx_wm = 4'd15;
            if (lvl < 16) push_rx(1);
        end
        chk("R5", "no overrun before extra push", int'(raw_irq[0]), 0);
        push_rx(1);
        chk("R5", "overrun raised", int'(raw_irq[0]), 1);
        chk("R3", "rx overflow sticky", int'(rx_ovfl), 1);
        chk("R3", "rx level kept", int'(rx_level), 16);

        // masking
        wmask(7'b0100000);
        chk("R9", "masked rx full only", int'(masked_irq), 32);
        chk("R9", "irq on", int'(irq), 1);
        wmask(7'b0000000);
        chk("R9", "masked all off", int'(masked_irq), 0);
        chk("R9", "irq off", int'(irq), 0);
        chk("R5", "overrun held", int'(raw_irq[0]), 1);

        // clear other bit leaves overrun
        clr_wr = 1'b1; clr_wdata = 7'b0000010; #1;
        chk("R7", "no flush for bit1 clear", int'(rx_flush), 0);
        step(); clr_wr = 1'b0; clr_wdata = '0;
        chk("R7", "overrun kept after bit1 clear", int'(raw_irq[0]), 1);
        chk("R7", "rx level kept after bit1 clear", int'(rx_level), 16);
        clr_wr = 1'b1; clr_wdata = 7'b0000001; #1;
        chk("R7", "flush strobe on bit0 clear", int'(rx_flush), 1);
        step(); clr_wr = 1'b0; clr_wdata = '0;
        chk("R7", "overrun cleared", int'(raw_irq[0]), 0);
        chk("R7", "rx emptied by overrun clear", int'(rx_level), 0);
        chk("R3", "rx overflow stays after clear", int'(rx_ovfl), 1);

        // mask write clears
        push_rx(17);
        chk("R5", "overrun again", int'(raw_irq[0]), 1);
        wmask(7'b0000011);
        chk("R8", "mask write cleared overrun", int'(raw_irq[0]), 0);
        chk("R8", "mask write emptied rx", int'(rx_level), 0);
        push_rx(17);
        chk("R8", "masked overrun after mask write", int'(masked_irq), 1);
        chk("R9", "irq from overrun", int'(irq), 1);
        clr(7'b0000001);

        // receive timeout
        push_rx(1);
        ticks(31);
        chk("R6", "no timeout after 31 ticks", int'(raw_irq[1]), 0);
        ticks(1);
        chk("R6", "timeout after 32 ticks", int'(raw_irq[1]), 1);
        chk("R9", "masked timeout", int'(masked_irq), 2);
        clr(7'b0000010);
        chk("R7", "timeout cleared", int'(raw_irq[1]), 0);
        push_rx(1);
        ticks(20);
        pop_rx(1);
        ticks(31);
        chk("R6", "pop restarted count", int'(raw_irq[1]), 0);
        ticks(1);
        chk("R6", "timeout after restart", int'(raw_irq[1]), 1);
        clr(7'b0000010);
        pop_rx(1);
        ticks(40);
        chk("R6", "no timeout while empty", int'(raw_irq[1]), 0);

        // simultaneous push and pop
        push_tx(3);
        tx_push = 1'b1; tx_pop = 1'b1; step(); tx_push = 1'b0; tx_pop = 1'b0;
        chk("R1", "tx push+pop keeps level", int'(tx_level), 3);

        // DMA gating
        push_rx(5);
        tx_dma_en = 1'b0; #1;
        chk("R12", "tx dma off by enable", int'({tx_dma_single, tx_dma_burst}), 0);
        chk("R10", "rx dma still on", int'({rx_dma_single, rx_dma_burst}), 3);
        tx_dma_en = 1'b1; rx_dma_en = 1'b0; #1;
        chk("R12", "rx dma off by enable", int'({rx_dma_single, rx_dma_burst}), 0);
        chk("R11", "tx dma back on", int'({tx_dma_single, tx_dma_burst}), 3);
        rx_dma_en = 1'b1; mod_en = 1'b0; #1;
        chk("R12", "all dma off by module disable",
            int'({rx_dma_single, rx_dma_burst, tx_dma_single, tx_dma_burst}), 0);
        mod_en = 1'b1;

        // soft reset
        push_rx(12);
        chk("R5", "overrun before soft reset", int'(raw_irq[0]), 1);
        wmask(7'b1000000);
        chk("R8", "bit6 mask write leaves overrun", int'(raw_irq[0]), 1);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        chk("R13", "tx level after soft reset", int'(tx_level), 0);
        chk("R13", "rx level after soft reset", int'(rx_level), 0);
        chk("R13", "sticky flags after soft reset",
            int'({tx_ovfl, tx_undr, rx_ovfl, rx_undr}), 0);
        chk("R13", "raw after soft reset", int'(raw_irq), 64);
        chk("R13", "mask kept after soft reset", int'(masked_irq), 64);
        chk("R9", "irq from tx empty", int'(irq), 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule